// File: doc/BRIEF.md
# Bit-Serial Lookup-Table FIR Filter

This block is a fixed-coefficient FIR filter that uses no multiplier. The coefficients are a parameter. At elaboration the block turns them into a lookup table with one entry for each possible pattern of one bit taken across all taps. Each entry holds the sum of the coefficients whose taps have that bit set.

When a sample is accepted, it enters the delay line. The engine then visits the bit positions of the stored samples one per clock, starting at the least significant bit. At each step it feeds the table output into a shift-accumulator. The step for the sign bit subtracts instead of adds, because the samples are two's complement. When the last bit is done, the full-precision sum is rounded, saturated and presented with a one-cycle valid strobe.

The upstream side offers a sample only while `in_ready` is high. Throughput is one output per `IN_W + 1` clocks when samples are offered back to back. The work per output is the same whatever the coefficient values are.

Top module: `da_fir`

## Requirements
- R1: The filter output is computed without multiplication. Table entry `a` (2^NTAPS entries) equals the sum of the coefficients of every tap `i` whose address bit `a[i]` is 1.
- R2: Bit positions are processed from bit 0 up to bit IN_W-1, one per clock. The table value at bit IN_W-1 is subtracted, so negative samples are weighted correctly.
- R3: The output equals sum(c_i * x_i), rounded to nearest with ties toward positive infinity by adding 2^(DROP-1) and arithmetic-shifting right by DROP. Tap 0 holds the newest sample.
- R4: `in_valid` is accepted only while `in_ready` is 1. A sample offered while `in_ready` is 0 has no effect on any later output.
- R5: `out_valid` is a single-cycle pulse raised exactly IN_W clock edges after the accepting edge. `in_ready` is 0 from the accepting edge until `out_valid` rises.
- R6: Each accepted sample shifts the delay line by one. The sample accepted NTAPS acceptances earlier no longer contributes.
- R7: A synchronous reset empties the delay line and sets `out_data` to 0, `out_valid` to 0 and `in_ready` to 1. The first result after reset reflects a zero-valued history.
- R8: A rounded result above 2^(OUT_W-1)-1 or below -2^(OUT_W-1) is clamped to that limit.
- R9: `out_data` holds its value between result strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered |
| in_data | input | IN_W | Signed input sample |
| in_ready | output | 1 | Engine idle, a sample may be accepted |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | OUT_W | Signed rounded, saturated result |

## Verification
The bench uses the default build: 8 symmetric taps with both negative and large positive coefficients, 10-bit samples, a 9-bit rounding drop and a 10-bit output. With these values, full-scale inputs drive the rounded sum well past the output range, so clamping is reached at both ends. A coefficient of 480 against a sample of ±8 lands exactly on a rounding tie. Extreme samples such as -512 exercise the subtracting sign step, and a 10-cycle busy window leaves room to offer ignored samples mid-computation.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  // Round half toward +inf by dropping `drop` LSBs
  function automatic longint round_drop(input longint v, input int drop);
    longint half;
    if (drop <= 0) return v;
    half = longint'(1) <<< (drop - 1);
    return (v + half) >>> drop;
  endfunction

  // Clamp to a signed range of `w` bits
  function automatic longint clamp_to(input longint v, input int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/da_fir_taps.sv
module da_fir_taps #(
  parameter int NTAPS = 8,
  parameter int IN_W  = 10,
  parameter int SEL_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    shift_en,
  input  logic signed [IN_W-1:0]  din,
  input  logic [SEL_W-1:0]        bit_sel,
  output logic [NTAPS-1:0]        bit_slice
);

  logic signed [IN_W-1:0] line_q [NTAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAPS; i++) line_q[i] <= '0;
    end else if (shift_en) begin
      line_q[0] <= din;
      for (int i = 1; i < NTAPS; i++) line_q[i] <= line_q[i-1];
    end
  end

  for (genvar t = 0; t < NTAPS; t++) begin : g_slice
    assign bit_slice[t] = line_q[t][bit_sel];
  end

endmodule

// File: rtl/da_fir_table.sv
module da_fir_table #(
  parameter int NTAPS  = 8,
  parameter int COEF_W = 10,
  parameter int TBL_W  = 14,
  parameter logic [NTAPS*COEF_W-1:0] COEFS = '0
) (
  input  logic [NTAPS-1:0]        addr,
  output logic signed [TBL_W-1:0] value
);

  localparam int DEPTH = 1 << NTAPS;

  function automatic longint entry_sum(input int a);
    longint s;
    s = 0;
    for (int i = 0; i < NTAPS; i++)
      if (a[i]) s += longint'($signed(COEFS[i*COEF_W +: COEF_W]));
    return s;
  endfunction

  logic signed [TBL_W-1:0] rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_entry
    assign rom[a] = TBL_W'(entry_sum(a));
  end

  assign value = rom[addr];

endmodule

// File: rtl/da_fir_engine.sv
module da_fir_engine #(
  parameter int IN_W   = 10,
  parameter int TBL_W  = 14,
  parameter int SEL_W  = 4,
  parameter int FULL_W = 25
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic signed [TBL_W-1:0]  tbl,
  output logic                     busy,
  output logic [SEL_W-1:0]         bit_idx,
  output logic                     step_last,
  output logic                     fin_valid,
  output logic signed [FULL_W-1:0] fin_value
);

  localparam int HW = TBL_W + 1;
  localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(IN_W - 1);

  logic signed [HW-1:0]   hi_q;
  logic [IN_W-1:0]        lo_q;
  logic signed [HW-1:0]   tbl_x;
  logic signed [HW-1:0]   step_sum;
  logic signed [HW-1:0]   hi_d;
  logic [IN_W-1:0]        lo_d;

  assign step_last = busy && (bit_idx == LAST_IDX);

  always_comb begin
    tbl_x    = HW'(tbl);
    step_sum = (bit_idx == LAST_IDX) ? (hi_q - tbl_x) : (hi_q + tbl_x);
    hi_d     = step_sum >>> 1;
    lo_d     = {step_sum[0], lo_q[IN_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      bit_idx   <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      fin_valid <= 1'b0;
      fin_value <= '0;
    end else begin
      fin_valid <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          bit_idx <= '0;
          hi_q    <= '0;
          lo_q    <= '0;
        end
      end else begin
        hi_q    <= hi_d;
        lo_q    <= lo_d;
        bit_idx <= bit_idx + 1'b1;
        if (step_last) begin
          busy      <= 1'b0;
          fin_valid <= 1'b1;
          fin_value <= {hi_d, lo_d};
        end
      end
    end
  end

endmodule

// File: rtl/da_fir.sv
module da_fir #(
  parameter int NTAPS  = 8,
  parameter int IN_W   = 10,
  parameter int COEF_W = 10,
  parameter int OUT_W  = 10,
  parameter int DROP   = 9,
  parameter logic [NTAPS*COEF_W-1:0] COEFS = {
    -10'sd23, 10'sd57, 10'sd211, 10'sd480,
    10'sd480, 10'sd211, 10'sd57, -10'sd23}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    in_ready,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);

  import da_fir_pkg::*;

  localparam int SEL_W  = (IN_W > 1) ? $clog2(IN_W) : 1;
  localparam int TBL_W  = COEF_W + $clog2(NTAPS) + 1;
  localparam int FULL_W = TBL_W + 1 + IN_W;

  logic                     eng_busy;
  logic                     eng_last;
  logic [SEL_W-1:0]         eng_cnt;
  logic [NTAPS-1:0]         slice;
  logic signed [TBL_W-1:0]  tbl_val;
  logic signed [FULL_W-1:0] full_sum;
  logic                     accept;

  assign in_ready = !eng_busy;
  assign accept   = in_valid && in_ready;

  da_fir_taps #(.NTAPS(NTAPS), .IN_W(IN_W), .SEL_W(SEL_W)) u_taps (
    .clk(clk), .rst(rst), .shift_en(accept), .din(in_data),
    .bit_sel(eng_cnt), .bit_slice(slice)
  );

  da_fir_table #(.NTAPS(NTAPS), .COEF_W(COEF_W), .TBL_W(TBL_W),
                 .COEFS(COEFS)) u_tbl (
    .addr(slice), .value(tbl_val)
  );

  da_fir_engine #(.IN_W(IN_W), .TBL_W(TBL_W), .SEL_W(SEL_W),
                  .FULL_W(FULL_W)) u_eng (
    .clk(clk), .rst(rst), .start(accept), .tbl(tbl_val),
    .busy(eng_busy), .bit_idx(eng_cnt), .step_last(eng_last),
    .fin_valid(out_valid), .fin_value(full_sum)
  );

  assign out_data = OUT_W'(clamp_to(round_drop(longint'(full_sum), DROP), OUT_W));

endmodule

// File: rtl/da_fir_chk.sv
module da_fir_chk #(
  parameter int SEL_W = 4,
  parameter int OUT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data,
  input logic             eng_last,
  input logic [SEL_W-1:0] eng_cnt
);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r5_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  a_r4_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !eng_last) |=> !in_ready);

  a_r2_bit_advance: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !eng_last) |=> (eng_cnt == SEL_W'($past(eng_cnt) + 1'b1)));

  a_r5_done_after_last: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && eng_last) |=> (out_valid && in_ready));

  a_r9_out_hold: assert property (@(posedge clk) disable iff (rst)
    !(!in_ready && eng_last) |=> $stable(out_data));

endmodule

bind da_fir da_fir_chk #(.SEL_W(SEL_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data),
  .eng_last(eng_last), .eng_cnt(eng_cnt)
);

// File: tb/da_fir_tb_top.sv
module da_fir_tb_top;

  localparam int NTAPS = 8;
  localparam int IN_W  = 10;
  localparam int OUT_W = 10;
  localparam int DROP  = 9;
  localparam int CF [NTAPS] = '{-23, 57, 211, 480, 480, 211, 57, -23};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_data = '0;
  logic in_ready;
  logic out_valid;
  logic signed [OUT_W-1:0] out_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  longint hist [NTAPS];
  longint exp_q [$];
  int     cyc_q [$];
  string  tag_q [$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  da_fir dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Independent model: direct products, half-up rounding, clamping
  function automatic longint model_out();
    longint s = 0;
    longint r;
    longint hi = (longint'(1) <<< (OUT_W - 1)) - 1;
    longint lo = -(longint'(1) <<< (OUT_W - 1));
    for (int i = 0; i < NTAPS; i++) s += hist[i] * CF[i];
    r = s + (longint'(1) <<< (DROP - 1));
    r = (r < 0) ? -((-r + (longint'(1) <<< DROP) - 1) / (longint'(1) <<< DROP))
                : r / (longint'(1) <<< DROP);
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < NTAPS; i++) hist[i] = 0;
  endtask

  task automatic send(input int x, input string tag);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = IN_W'(x);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = NTAPS - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    exp_q.push_back(model_out());
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  // Offer junk while busy; must be ignored (R4)
  task automatic send_then_poke(input int x, input int junk);
    send(x, "R4");
    for (int k = 0; k < 4; k++) begin
      check(in_ready == 1'b0, "R5 ready low while busy", in_ready, 0);
      in_valid = 1'b1;
      in_data  = IN_W'(junk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid && !finished) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected strobe", 1, 0);
      end else begin
        longint e;
        int c0;
        string t;
        e  = exp_q.pop_front();
        c0 = cyc_q.pop_front();
        t  = tag_q.pop_front();
        check(longint'(out_data) == e, t, longint'(out_data), e);
        check(cyc - c0 == IN_W, "R5 latency", cyc - c0, IN_W);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7 reset state
    check(out_valid == 1'b0, "R7 out_valid after reset", out_valid, 0);
    check(out_data == '0, "R7 out_data after reset", out_data, 0);
    check(in_ready == 1'b1, "R7 in_ready after reset", in_ready, 1);

    // R1 / R6 impulse walks through the taps, then falls off
    send(100, "R1 impulse");
    for (int i = 0; i < NTAPS; i++) send(0, "R6 shift");
    drain();

    // R2 / R3 signed mixed patterns, incl. extreme values
    send(-512, "R2 min sample");
    send(511, "R2 max sample");
    send(-1, "R2 minus one");
    send(37, "R3 mixed");
    send(-200, "R3 mixed");
    send(300, "R3 mixed");
    send(-77, "R2 neg");
    send(5, "R3 mixed");
    send(-512, "R2 min sample");
    drain();

    // R3 rounding ties: 480*8/512 = 7.5 -> 8, -7.5 -> -7
    for (int i = 0; i < NTAPS; i++) send(0, "R6 flush");
    send(8, "R3 tie pos");
    send(0, "R3"); send(0, "R3"); send(0, "R3 tie pos at tap3");
    for (int i = 0; i < NTAPS; i++) send(0, "R6 flush");
    send(-8, "R3 tie neg");
    send(0, "R3"); send(0, "R3"); send(0, "R3 tie neg at tap3");
    drain();

    // R8 saturation both ways
    for (int i = 0; i < NTAPS; i++) send(511, "R8 clamp high");
    for (int i = 0; i < NTAPS; i++) send(-512, "R8 clamp low");
    drain();

    // R9 hold between strobes
    begin
      logic signed [OUT_W-1:0] held;
      held = out_data;
      repeat (5) @(negedge clk);
      check(out_data == held, "R9 hold", out_data, held);
    end

    // R4 samples offered while busy are dropped
    for (int i = 0; i < NTAPS; i++) send(0, "R6 flush");
    send_then_poke(120, 400);
    send_then_poke(-60, -300);
    send(0, "R4 after poke");
    drain();

    // R7 reset mid-history
    send(250, "R7 pre");
    send(-250, "R7 pre");
    drain();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    clear_model();
    check(out_data == '0, "R7 out_data after mid reset", out_data, 0);
    check(in_ready == 1'b1, "R7 ready after mid reset", in_ready, 1);
    send(64, "R7 zero history");
    send(0, "R7 zero history");
    drain();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule